// File: doc/BRIEF.md
# Block-Write Configuration Slave

This block is a write-only slave on a two-wire serial bus of the SMBus/I2C kind. It loads a small file of configuration registers for a clock generator. The bus clock and data lines arrive as plain inputs and are oversampled by the system clock. The block acknowledges a byte by asserting an output that pulls the data line low through an open-drain pad. Three strap inputs choose the slave address from a fixed table of eight 8-bit address bytes, and that table does not run in order.

A transfer is accepted only in one form. The master sends a start, then the address byte with its direction bit at 0, then the command code 0x00, then a byte count, then the data bytes. The slave acknowledges each of these bytes. The first data byte always goes to register 0, and each further byte goes to the next register. A data byte whose index is past the last register, or past the byte count, is still acknowledged but is then dropped. A read request is never acknowledged. A stop may arrive after any byte. A repeated start returns the slave to the address phase.

The register values appear in parallel on one registered output vector. Each register takes a fixed value after reset.

Top module: `cfgslv_top`

## Requirements
- R1: While `rst` is high and after it falls, `cfg_o` holds 0xFFFFA1: register 0 sits in bits 7:0 and reads 0xA1, register 1 sits in bits 15:8 and reads 0xFF, and register 2 sits in bits 23:16 and reads 0xFF.
- R2: The address byte the slave answers to depends on `strap_i` = {IA2,IA1,IA0}: 0→0xDE, 1→0xDC, 2→0xDA, 3→0xD8, 4→0xD6, 5→0xD4, 6→0xD0, 7→0xD2. The byte's bit 0 is the direction bit, and 0 means write.
- R3: When a byte is acknowledged, `sda_pull_o` rises after the SCL falling edge that ends the eighth bit. It stays steady while SCL is high and falls after the next SCL falling edge.
- R4: An address byte that does not match, or that has the read bit (bit 0 = 1), is not acknowledged. The slave then ignores the bus until the next start and leaves `cfg_o` unchanged.
- R5: The command byte must be 0x00 to be acknowledged. Any other value is not acknowledged, ends the transfer and writes nothing.
- R6: The byte count and every data byte are acknowledged. Data bytes are shifted in most significant bit first and written to register 0, 1 and 2 in that order.
- R7: After a stop that follows any complete byte, the registers already written keep their new values and the others keep their old ones.
- R8: A data byte is acknowledged but discarded when its index is 3 or more, or when its index is equal to or greater than the byte count.
- R9: A start seen in any phase, including mid-transfer, returns the slave to the address phase, and the next data byte goes to register 0 again.
- R10: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high, both judged after two-flop synchronisation. A stop releases `sda_pull_o`, and bytes clocked in without a start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 3 | Address strap {IA2,IA1,IA0} |
| sda_pull_o | output | 1 | High pulls the data line low (acknowledge) |
| cfg_o | output | 24 | Register file, register k in bits 8k+7:8k |

## Verification
The SCL falling edge that closes a data byte does two things in the same system cycle: it commits the register write and it begins the acknowledge pull-down. At that edge the slave also decides, in the same cycle, whether an index past the last register or past the count is discarded. The bench covers this by sending byte counts that are smaller than, equal to and larger than the register file. It then judges the acknowledge seen on the wired data line during each ninth clock, and it compares the full register vector after each stop against a model that applies the discard rules on their own. A repeated start placed at the point where the slave expects a command byte checks that the phase is reset in the cycle the start is detected.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_DATA
  } phase_e;

  // Strap to 8-bit address byte; the table is not monotonic at the top end.
  function automatic logic [7:0] strap_to_addr(input logic [2:0] s);
    logic [7:0] a;
    if (s[2] && s[1]) a = 8'hD0 + 8'({s[0], 1'b0});
    else              a = 8'hDE - 8'({s, 1'b0});
    return a;
  endfunction

endpackage

// File: rtl/cfgslv_sync.sv
module cfgslv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgslv_shifter.sv
module cfgslv_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          restart,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          ack_req,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic          sda_pull
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW);
  localparam logic [CW-1:0] ACK_SLOT = CW'(DW + 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;

  assign byte_done = active && scl_fall && (cnt == LAST_BIT);
  assign rx_byte   = sh;

  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      cnt      <= '0;
      sda_pull <= 1'b0;
      if (rst) sh <= '0;
    end else if (byte_done) begin
      if (ack_req) begin
        sda_pull <= 1'b1;
        cnt      <= ACK_SLOT;
      end else begin
        cnt <= '0;
      end
    end else if (scl_fall && cnt == ACK_SLOT) begin
      sda_pull <= 1'b0;
      cnt      <= '0;
    end else if (scl_rise && cnt < LAST_BIT) begin
      sh  <= {sh[DW-2:0], sda_s};
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfgslv_ctrl.sv
module cfgslv_ctrl
  import cfgslv_pkg::*;
#(
  parameter int          NREG      = 3,
  parameter int          DW        = 8,
  parameter logic [7:0]  CMD_BLOCK = 8'h00,
  localparam int         IDXW      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic            byte_done,
  input  logic [DW-1:0]   rx_byte,
  input  logic [7:0]      own_addr,
  output logic            active,
  output logic            ack_req,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data
);
  phase_e        phase;
  logic [DW-1:0] idx;
  logic [DW-1:0] count;

  assign active = (phase != PH_IDLE);

  always_comb begin
    unique case (phase)
      PH_ADDR:           ack_req = (rx_byte == own_addr);
      PH_CMD:            ack_req = (rx_byte == CMD_BLOCK);
      PH_COUNT, PH_DATA: ack_req = 1'b1;
      default:           ack_req = 1'b0;
    endcase
  end

  assign wr_en   = byte_done && (phase == PH_DATA) && (int'(idx) < NREG) && (idx < count);
  assign wr_idx  = idx[IDXW-1:0];
  assign wr_data = rx_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      idx   <= '0;
      count <= '0;
    end else if (start_det) begin
      phase <= PH_ADDR;
      idx   <= '0;
    end else if (stop_det) begin
      phase <= PH_IDLE;
    end else if (byte_done) begin
      unique case (phase)
        PH_ADDR:  phase <= ack_req ? PH_CMD : PH_IDLE;
        PH_CMD:   phase <= ack_req ? PH_COUNT : PH_IDLE;
        PH_COUNT: begin
          count <= rx_byte;
          idx   <= '0;
          phase <= PH_DATA;
        end
        PH_DATA:  if (idx != '1) idx <= idx + 1'b1;
        default:  phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgslv_regs.sv
module cfgslv_regs #(
  parameter int                 NREG     = 3,
  parameter int                 DW       = 8,
  parameter logic [NREG*DW-1:0] DEFAULTS = 24'hFFFFA1,
  localparam int                IDXW     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] cfg_o
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) mem[k] <= DEFAULTS[k*DW +: DW];
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_o[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/cfgslv_top.sv
module cfgslv_top
  import cfgslv_pkg::*;
#(
  parameter int                 NREG        = 3,
  parameter int                 DW          = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [7:0]         CMD_BLOCK   = 8'h00,
  parameter logic [NREG*DW-1:0] DEFAULTS    = 24'hFFFFA1,
  localparam int                IDXW        = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [2:0]         strap_i,
  output logic               sda_pull_o,
  output logic [NREG*DW-1:0] cfg_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic active, ack_req, byte_done, wr_en;
  logic [DW-1:0]   rx_byte, wr_data;
  logic [IDXW-1:0] wr_idx;
  logic [7:0]      own_addr;

  assign own_addr = strap_to_addr(strap_i);

  cfgslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst, .scl_i, .sda_i, .scl_s, .sda_s,
    .scl_rise, .scl_fall, .start_det, .stop_det
  );

  cfgslv_shifter #(.DW(DW)) u_shift (
    .clk, .rst, .active,
    .restart (start_det | stop_det),
    .scl_rise, .scl_fall, .sda_s, .ack_req,
    .byte_done, .rx_byte,
    .sda_pull (sda_pull_o)
  );

  cfgslv_ctrl #(.NREG(NREG), .DW(DW), .CMD_BLOCK(CMD_BLOCK)) u_ctrl (
    .clk, .rst, .start_det, .stop_det, .byte_done, .rx_byte, .own_addr,
    .active, .ack_req, .wr_en, .wr_idx, .wr_data
  );

  cfgslv_regs #(.NREG(NREG), .DW(DW), .DEFAULTS(DEFAULTS)) u_regs (
    .clk, .rst, .wr_en, .wr_idx, .wr_data, .cfg_o
  );
endmodule

// File: rtl/cfgslv_checker.sv
module cfgslv_checker #(
  parameter int          W   = 24,
  parameter logic [W-1:0] DEF = 24'hFFFFA1
) (
  input logic         clk,
  input logic         rst,
  input logic         scl_s,
  input logic         scl_fall,
  input logic         stop_det,
  input logic         active,
  input logic         wr_en,
  input logic         sda_pull_o,
  input logic [W-1:0] cfg_o
);
  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    rst |=> (cfg_o == DEF)); // R1

  AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> $past(scl_fall)); // R3

  AST_ACK_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_o)); // R3

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !active |-> !wr_en); // R4

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_o)); // R6

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_o); // R10
endmodule

bind cfgslv_top cfgslv_checker #(.W(NREG*DW), .DEF(DEFAULTS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_s      (scl_s),
  .scl_fall   (scl_fall),
  .stop_det   (stop_det),
  .active     (active),
  .wr_en      (wr_en),
  .sda_pull_o (sda_pull_o),
  .cfg_o      (cfg_o)
);

// File: tb/cfgslv_top_bench.sv
module cfgslv_top_bench;
  localparam int Q = 6;
  localparam int H = 12;

  typedef struct {
    bit          is_cfg;
    string       tag;
    logic [31:0] exp_v;
    logic [31:0] act_v;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  strap = 3'd0;
  logic        sda_line;
  logic        sda_pull;
  logic [23:0] cfg;

  sb_item_t sbq[$];
  event     ev_chk;
  int       n_chk = 0;
  int       n_fail = 0;
  bit       done = 1'b0;
  logic [7:0] mdl [3];

  assign sda_line = sda_m & ~sda_pull;
  always #4 clk = ~clk;

  cfgslv_top u_cfgslv_top (
    .clk, .rst, .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .sda_pull_o(sda_pull), .cfg_o(cfg)
  );

  function automatic logic [7:0] exp_addr(input logic [2:0] s);
    case (s)
      3'd0: return 8'hDE;
      3'd1: return 8'hDC;
      3'd2: return 8'hDA;
      3'd3: return 8'hD8;
      3'd4: return 8'hD6;
      3'd5: return 8'hD4;
      3'd6: return 8'hD0;
      default: return 8'hD2;
    endcase
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_item(input bit is_cfg, input string tag,
                           input logic [31:0] e, input logic [31:0] a);
    sb_item_t it;
    it.is_cfg = is_cfg; it.tag = tag; it.exp_v = e; it.act_v = a;
    sbq.push_back(it);
    -> ev_chk;
  endtask

  task automatic expect_cfg(input string tag);
    push_item(1'b1, tag, {8'h00, mdl[2], mdl[1], mdl[0]}, 32'h0);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(H);
    sda_m = 1'b0; wait_cyc(H);
    scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(H);
    sda_m = 1'b1; wait_cyc(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_cyc(Q);
      scl_m = 1'b1; wait_cyc(H);
      scl_m = 1'b0; wait_cyc(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    logic obs;
    send_bits(b, 8);
    sda_m = 1'b1; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(H / 2);
    obs = ~sda_line;
    wait_cyc(H / 2);
    scl_m = 1'b0; wait_cyc(Q);
    push_item(1'b0, tag, {31'd0, exp_ack}, {31'd0, obs});
  endtask

  task automatic data_byte(input logic [7:0] b, input int idx, input int cnt, input string tag);
    send_byte(b, 1'b1, tag);
    if (idx < 3 && idx < cnt) mdl[idx] = b;
  endtask

  task automatic open_write(input logic [7:0] cnt, input string tag);
    bus_start();
    send_byte(exp_addr(strap), 1'b1, tag);
    send_byte(8'h00, 1'b1, tag);
    send_byte(cnt, 1'b1, tag);
  endtask

  // Scoreboard monitor
  initial begin
    sb_item_t it;
    logic [31:0] act;
    forever begin
      @(ev_chk);
      while (sbq.size() > 0) begin
        it  = sbq.pop_front();
        act = it.is_cfg ? {8'h00, cfg} : it.act_v;
        n_chk++;
        if (act !== it.exp_v) begin
          n_fail++;
          $display("FAIL %s %s act=%h exp=%h", it.tag, it.is_cfg ? "cfg" : "ack", act, it.exp_v);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    mdl[0] = 8'hA1; mdl[1] = 8'hFF; mdl[2] = 8'hFF;
    wait_cyc(5);
    expect_cfg("R1 during reset");
    rst = 1'b0;
    wait_cyc(5);
    expect_cfg("R1 after reset");

    // Full three-byte block write, MSB first
    strap = 3'd0;
    open_write(8'd3, "R3 header");
    data_byte(8'h3C, 0, 3, "R6 data0");
    data_byte(8'h5A, 1, 3, "R6 data1");
    data_byte(8'h81, 2, 3, "R6 data2");
    bus_stop(); wait_cyc(4);
    expect_cfg("R6 three bytes");

    // Address table sweep, wrong address and read bit
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      wait_cyc(4);
      bus_start(); send_byte(exp_addr(3'(s)), 1'b1, "R2 match"); bus_stop();
      bus_start(); send_byte(exp_addr(3'(s)) ^ 8'h04, 1'b0, "R4 wrong addr"); bus_stop();
      bus_start(); send_byte(exp_addr(3'(s)) | 8'h01, 1'b0, "R4 read bit");
      send_byte(8'h00, 1'b0, "R4 ignored after nack"); bus_stop();
    end
    wait_cyc(4);
    expect_cfg("R4 no change");

    // Non-block command
    strap = 3'd5;
    wait_cyc(4);
    bus_start();
    send_byte(exp_addr(strap), 1'b1, "R5 addr");
    send_byte(8'h05, 1'b0, "R5 bad cmd");
    send_byte(8'h01, 1'b0, "R5 after bad cmd");
    send_byte(8'h77, 1'b0, "R5 after bad cmd");
    bus_stop(); wait_cyc(4);
    expect_cfg("R5 no write");

    // Stop after one data byte
    open_write(8'd3, "R7 header");
    data_byte(8'hC3, 0, 3, "R7 data0");
    bus_stop(); wait_cyc(4);
    expect_cfg("R7 partial");

    // Count smaller than data
    open_write(8'd1, "R8 header");
    data_byte(8'h11, 0, 1, "R8 in count");
    data_byte(8'h22, 1, 1, "R8 past count");
    data_byte(8'h33, 2, 1, "R8 past count");
    bus_stop(); wait_cyc(4);
    expect_cfg("R8 count limit");

    // Data beyond the register file
    open_write(8'd5, "R8 header5");
    for (int i = 0; i < 5; i++) data_byte(8'h44 + 8'(i) * 8'h11, i, 5, "R8 beyond file");
    bus_stop(); wait_cyc(4);
    expect_cfg("R8 file limit");

    // Repeated start after a data byte
    open_write(8'd2, "R9 first");
    data_byte(8'h99, 0, 2, "R9 first data");
    open_write(8'd2, "R9 second");
    data_byte(8'hAB, 0, 2, "R9 restart idx0");
    data_byte(8'hCD, 1, 2, "R9 restart idx1");
    bus_stop(); wait_cyc(4);
    expect_cfg("R9 restart data");

    // Repeated start where a command byte is due
    bus_start();
    send_byte(exp_addr(strap), 1'b1, "R9 addr");
    bus_start();
    send_byte(exp_addr(strap), 1'b1, "R9 addr phase again");
    send_byte(8'h00, 1'b1, "R9 cmd");
    bus_stop();

    // Bytes without a start; stop inside a byte
    wait_cyc(4);
    send_byte(exp_addr(strap), 1'b0, "R10 no start");
    bus_stop();
    open_write(8'd2, "R10 header");
    send_bits(8'hF0, 4);
    bus_stop(); wait_cyc(4);
    expect_cfg("R10 stop mid byte");
    open_write(8'd1, "R10 after stop");
    data_byte(8'h6E, 0, 1, "R10 data");
    bus_stop(); wait_cyc(4);
    expect_cfg("R10 recovered");

    wait_cyc(10);
    -> ev_chk;
    wait_cyc(2);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule